// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Unit

This block holds an interrupt-enable word and an interrupt-status word for each of several localities (five by default) and drives one level-sensitive interrupt line. Event pulses arrive tagged with a locality and a four-bit source vector. Each pulse is latched into that locality's status word only when the locality has enabled interrupts both globally and for the matching source.

Register accesses come from an upstream address decoder. Each access carries the locality that issued it and the locality that currently owns the interface. Only the owning locality may change its enable or status words. Any locality may read. The interrupt line stays high while any locality has a non-zero status word. It falls once every status word has been cleared.

Top module: `lirq_unit`

Bit layout of both words: bit 0 data-available, bit 1 status-valid, bit 2 locality-changed, bit 3 command-ready. In the enable word, bits 5:4 hold the polarity field (2'b01 = low level) and bit 31 is the global enable. Register selects are `acc_sel` 0 = enable, 1 = status, 2 = vector. A locality value of `NUM_LOC` or above means "no locality".

## Requirements
- R1: An event sets status bit k of locality L only if enable bit 31 and enable bit k of L are both 1. Source bits k whose enable is 0 leave status bit k unchanged.
- R2: An event whose locality is not below `NUM_LOC` changes no status word.
- R3: An enable or status write whose `acc_loc` differs from `act_loc` changes neither word of any locality.
- R4: An enable write replaces only the byte lanes with `wr_be` set. Within those lanes it keeps only bits 31, 5:4 and 3:0 of `wr_data`; every other bit is written as 0.
- R5: Writing 1 to bit k (k = 0..3) of the status word clears that bit, but only inside byte lanes selected by `wr_be`. Bits written as 0 are left unchanged.
- R6: `irq` is 1 while any locality's status word is non-zero and 0 once all are zero, so clearing one locality does not lower a line that another still holds.
- R7: After reset every enable word reads 32'h0000_0010, every status word reads 0, and `irq` is 0.
- R8: A read of the vector select returns `VEC_VALUE`. Writes to it change nothing.
- R9: `rd_data` presents the selected word on the clock edge that samples `rd_en`. A read of a locality not below `NUM_LOC` returns 0.
- R10: When an event and a status clear hit the same locality on the same edge, bits set by the event stay set.
- R11: The status word and `irq` update on the same clock edge as the event or write that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event pulse valid |
| evt_loc | input | LOC_W | Locality the event belongs to |
| evt_src | input | 4 | Event sources (bit 0 data-avail, 1 sts-valid, 2 loc-change, 3 cmd-ready) |
| acc_loc | input | LOC_W | Locality issuing the register access |
| act_loc | input | LOC_W | Locality currently owning the interface |
| acc_sel | input | 2 | Register select: 0 enable, 1 status, 2 vector |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane enables for the write |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Registered level interrupt line |

## Verification
The gating is tried with several event patterns:
- all sources with only polarity enabled;
- source bits enabled but global enable off;
- sources outside the enabled set;
- sources partly inside the enabled set.

Together these separate a design that ignores either enable from one that masks per bit. Enable and status writes are issued with full, low-lane-only and high-lanes-only byte enables, and also from a locality other than the owner. This tells apart designs that drop lane sizing, the keep mask or the ownership check. The line is checked while two localities hold status and one is cleared, then again after the last is cleared. A same-edge event and clear checks that new events are never lost.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int REG_W   = 32;
  localparam int NSRC    = 4;
  localparam int GEN_BIT = 31;
  localparam logic [REG_W-1:0] SRC_BITS = 32'h0000_000F;
  localparam logic [REG_W-1:0] POL_BITS = 32'h0000_0030;
  localparam logic [REG_W-1:0] EN_KEEP  = SRC_BITS | POL_BITS | (32'h1 << GEN_BIT);
  localparam logic [REG_W-1:0] EN_RST   = 32'h0000_0010;
  typedef enum logic [1:0] {SEL_EN = 2'd0, SEL_STAT = 2'd1, SEL_VEC = 2'd2, SEL_NONE = 2'd3} reg_sel_e;
endpackage

// File: rtl/lirq_loc_regs.sv
module lirq_loc_regs
  import lirq_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int LOC_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evt_valid,
  input  logic [LOC_W-1:0]   evt_loc,
  input  logic [NSRC-1:0]    evt_src,
  input  logic               wr_en,
  input  logic [LOC_W-1:0]   acc_loc,
  input  logic [LOC_W-1:0]   act_loc,
  input  reg_sel_e           sel,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [REG_W/8-1:0] wr_be,
  output logic [REG_W-1:0]   en_q,
  output logic [REG_W-1:0]   stat_q,
  output logic [REG_W-1:0]   stat_nxt
);
  localparam logic [LOC_W-1:0] ME = LOC_W'(IDX);

  logic [REG_W-1:0] lane;
  logic [REG_W-1:0] en_nxt;
  logic [REG_W-1:0] clr;
  logic [NSRC-1:0]  gated;
  logic             mine;
  logic             hit;

  always_comb begin
    for (int b = 0; b < REG_W/8; b++) begin
      lane[b*8 +: 8] = {8{wr_be[b]}};
    end
  end

  // only the owning locality touching its own slice may write
  assign mine  = wr_en && (acc_loc == ME) && (act_loc == ME);
  assign hit   = evt_valid && (evt_loc == ME);
  assign gated = en_q[GEN_BIT] ? (evt_src & en_q[NSRC-1:0]) : '0;

  always_comb begin
    en_nxt = en_q;
    if (mine && sel == SEL_EN) begin
      en_nxt = (en_q & ~lane) | (wr_data & lane & EN_KEEP);
    end
    clr = (mine && sel == SEL_STAT) ? (wr_data & lane & SRC_BITS) : '0;
    // set after clear: an event on the same edge wins
    stat_nxt = (stat_q & ~clr) | (hit ? REG_W'(gated) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= EN_RST;
      stat_q <= '0;
    end else begin
      en_q   <= en_nxt;
      stat_q <= stat_nxt;
    end
  end
endmodule

// File: rtl/lirq_rd_mux.sv
module lirq_rd_mux
  import lirq_pkg::*;
#(
  parameter int               NUM_LOC   = 5,
  parameter int               LOC_W     = 3,
  parameter logic [REG_W-1:0] VEC_VALUE = 32'h0000_000B
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [LOC_W-1:0]         acc_loc,
  input  reg_sel_e                 sel,
  input  logic [NUM_LOC*REG_W-1:0] en_flat,
  input  logic [NUM_LOC*REG_W-1:0] stat_flat,
  output logic [REG_W-1:0]         rd_data
);
  localparam logic [LOC_W-1:0] LAST = LOC_W'(NUM_LOC - 1);

  logic [REG_W-1:0] word;

  always_comb begin
    word = '0;
    if (acc_loc <= LAST) begin
      unique case (sel)
        SEL_EN:   word = en_flat[int'(acc_loc)*REG_W +: REG_W];
        SEL_STAT: word = stat_flat[int'(acc_loc)*REG_W +: REG_W];
        SEL_VEC:  word = VEC_VALUE;
        default:  word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= word;
    end
  end
endmodule

// File: rtl/lirq_unit.sv
module lirq_unit
  import lirq_pkg::*;
#(
  parameter int               NUM_LOC   = 5,
  parameter logic [REG_W-1:0] VEC_VALUE = 32'h0000_000B,
  localparam int              LOC_W     = $clog2(NUM_LOC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evt_valid,
  input  logic [LOC_W-1:0]   evt_loc,
  input  logic [3:0]         evt_src,
  input  logic [LOC_W-1:0]   acc_loc,
  input  logic [LOC_W-1:0]   act_loc,
  input  logic [1:0]         acc_sel,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic [3:0]         wr_be,
  input  logic               rd_en,
  output logic [31:0]        rd_data,
  output logic               irq
);
  logic [NUM_LOC*REG_W-1:0] en_flat;
  logic [NUM_LOC*REG_W-1:0] stat_flat;
  logic [NUM_LOC*REG_W-1:0] stat_nxt_flat;
  logic                     irq_q;
  reg_sel_e                 sel;

  assign sel = reg_sel_e'(acc_sel);

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    lirq_loc_regs #(.IDX(i), .LOC_W(LOC_W)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .evt_valid(evt_valid),
      .evt_loc  (evt_loc),
      .evt_src  (evt_src),
      .wr_en    (wr_en),
      .acc_loc  (acc_loc),
      .act_loc  (act_loc),
      .sel      (sel),
      .wr_data  (wr_data),
      .wr_be    (wr_be),
      .en_q     (en_flat[i*REG_W +: REG_W]),
      .stat_q   (stat_flat[i*REG_W +: REG_W]),
      .stat_nxt (stat_nxt_flat[i*REG_W +: REG_W])
    );
  end

  lirq_rd_mux #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .VEC_VALUE(VEC_VALUE)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .acc_loc  (acc_loc),
    .sel      (sel),
    .en_flat  (en_flat),
    .stat_flat(stat_flat),
    .rd_data  (rd_data)
  );

  // line follows the next status words so it moves on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |stat_nxt_flat;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/lirq_chk.sv
module lirq_chk #(
  parameter int          NUM_LOC   = 5,
  parameter int          LOC_W     = 3,
  parameter logic [31:0] VEC_VALUE = 32'h0000_000B
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   evt_valid,
  input logic [LOC_W-1:0]       evt_loc,
  input logic [LOC_W-1:0]       acc_loc,
  input logic [LOC_W-1:0]       act_loc,
  input logic [1:0]             acc_sel,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [31:0]            rd_data,
  input logic                   irq,
  input logic [NUM_LOC*32-1:0]  en_flat,
  input logic [NUM_LOC*32-1:0]  stat_flat
);
  localparam logic [LOC_W-1:0] LAST = LOC_W'(NUM_LOC - 1);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  p_reset_clear_r7: assert property (@(posedge clk)
    rst_d |-> (irq == 1'b0 && stat_flat == '0));

  p_line_follows_status_r6: assert property (@(posedge clk) disable iff (rst)
    irq == (stat_flat != '0));

  p_foreign_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && acc_loc != act_loc && !evt_valid) |=> ($stable(stat_flat) && $stable(en_flat)));

  p_bad_event_r2: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_loc > LAST && !wr_en) |=> $stable(stat_flat));

  p_vector_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && acc_sel == 2'd2 && !evt_valid) |=> ($stable(stat_flat) && $stable(en_flat)));

  p_vector_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && acc_sel == 2'd2 && acc_loc <= LAST) |=> rd_data == VEC_VALUE);

  p_bad_loc_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && acc_loc > LAST) |=> rd_data == 32'h0);
endmodule

bind lirq_unit lirq_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .VEC_VALUE(VEC_VALUE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .evt_valid(evt_valid),
  .evt_loc  (evt_loc),
  .acc_loc  (acc_loc),
  .act_loc  (act_loc),
  .acc_sel  (acc_sel),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .irq      (irq),
  .en_flat  (en_flat),
  .stat_flat(stat_flat)
);

// File: tb/lirq_unit_bench.sv
module lirq_unit_bench;
  localparam int LW = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [LW-1:0] evt_loc = '0;
  logic [3:0]  evt_src = '0;
  logic [LW-1:0] acc_loc = '0;
  logic [LW-1:0] act_loc = 3'd2;
  logic [1:0]  acc_sel = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  lirq_unit u_lirq_unit (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_loc(evt_loc), .evt_src(evt_src),
    .acc_loc(acc_loc), .act_loc(act_loc), .acc_sel(acc_sel), .wr_en(wr_en),
    .wr_data(wr_data), .wr_be(wr_be), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  kind;  // 0 event, 1 write, 2 read-and-check
    logic [2:0]  loc;
    logic [2:0]  act;
    logic [1:0]  sel;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk(input logic [1:0] k, input logic [2:0] l, input logic [2:0] a,
                              input logic [1:0] s, input logic [3:0] b, input logic [31:0] d,
                              input logic [31:0] e, input logic i, input logic [3:0] r);
    mk = '{kind: k, loc: l, act: a, sel: s, be: b, data: d, exp: e, exp_irq: i, req: r};
  endfunction

  localparam int NV = 42;
  localparam vec_t TBL [NV] = '{
    mk(2, 0, 2, 0, 0, 0, 32'h10, 0, 7),                 // R7 enable reset value
    mk(2, 0, 2, 1, 0, 0, 32'h0, 0, 7),                  // R7 status reset value
    mk(0, 2, 2, 0, 0, 32'hF, 0, 0, 0),
    mk(2, 2, 2, 1, 0, 0, 32'h0, 0, 1),                  // R1 nothing enabled
    mk(1, 2, 2, 0, 4'hF, 32'h5, 0, 0, 0),
    mk(2, 2, 2, 0, 0, 0, 32'h5, 0, 4),                  // R4 full write
    mk(0, 2, 2, 0, 0, 32'hF, 0, 0, 0),
    mk(2, 2, 2, 1, 0, 0, 32'h0, 0, 1),                  // R1 no global enable
    mk(1, 2, 2, 0, 4'hF, 32'h8000_0005, 0, 0, 0),
    mk(0, 2, 2, 0, 0, 32'hA, 0, 0, 0),
    mk(2, 2, 2, 1, 0, 0, 32'h0, 0, 1),                  // R1 disabled sources
    mk(0, 2, 2, 0, 0, 32'h3, 0, 0, 0),
    mk(2, 2, 2, 1, 0, 0, 32'h1, 1, 1),                  // R1 partial overlap
    mk(1, 2, 2, 0, 4'hF, 32'hFFFF_FFFF, 0, 0, 0),
    mk(2, 2, 2, 0, 0, 0, 32'h8000_003F, 1, 4),          // R4 keep mask
    mk(1, 2, 2, 0, 4'h1, 32'h0, 0, 0, 0),
    mk(2, 2, 2, 0, 0, 0, 32'h8000_0000, 1, 4),          // R4 low lane only
    mk(1, 2, 2, 0, 4'hE, 32'hFF, 0, 0, 0),
    mk(2, 2, 2, 0, 0, 0, 32'h0, 1, 4),                  // R4 high lanes only
    mk(1, 2, 2, 0, 4'hF, 32'h8000_000F, 0, 0, 0),
    mk(1, 3, 2, 1, 4'hF, 32'hF, 0, 0, 0),
    mk(2, 2, 2, 1, 0, 0, 32'h1, 1, 3),                  // R3 foreign clear
    mk(1, 3, 2, 0, 4'hF, 32'h8000_000F, 0, 0, 0),
    mk(2, 3, 2, 0, 0, 0, 32'h10, 1, 3),                 // R3 foreign enable
    mk(1, 4, 4, 0, 4'hF, 32'h8000_000F, 0, 0, 0),
    mk(0, 5, 4, 0, 0, 32'hF, 0, 0, 0),
    mk(0, 7, 4, 0, 0, 32'hF, 0, 0, 0),
    mk(2, 4, 4, 1, 0, 0, 32'h0, 1, 2),                  // R2 invalid event locality
    mk(0, 4, 4, 0, 0, 32'h4, 0, 0, 0),
    mk(2, 4, 4, 1, 0, 0, 32'h4, 1, 1),                  // R1 second locality
    mk(1, 2, 2, 1, 4'hF, 32'h1, 0, 0, 0),
    mk(2, 2, 2, 1, 0, 0, 32'h0, 1, 6),                  // R6 other locality holds line
    mk(1, 4, 4, 1, 4'hE, 32'h4, 0, 0, 0),
    mk(2, 4, 4, 1, 0, 0, 32'h4, 1, 5),                  // R5 lane not selected
    mk(1, 4, 4, 1, 4'hF, 32'h2, 0, 0, 0),
    mk(2, 4, 4, 1, 0, 0, 32'h4, 1, 5),                  // R5 zero bits keep
    mk(1, 4, 4, 1, 4'hF, 32'h4, 0, 0, 0),
    mk(2, 4, 4, 1, 0, 0, 32'h0, 0, 6),                  // R6 last clear drops line
    mk(1, 2, 2, 2, 4'hF, 32'hFFFF_FFFF, 0, 0, 0),
    mk(2, 2, 2, 2, 0, 0, 32'h0000_000B, 0, 8),          // R8 vector read
    mk(2, 2, 2, 0, 0, 0, 32'h8000_000F, 0, 8),          // R8 vector write ignored
    mk(2, 6, 2, 0, 0, 0, 32'h0, 0, 9)                   // R9 invalid read locality
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    evt_valid = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] l, input logic [1:0] s);
    @(negedge clk);
    idle(); rd_en = 1'b1; acc_loc = l; acc_sel = s;
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R7 irq after reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      act_loc = TBL[i].act;
      case (TBL[i].kind)
        2'd0: begin evt_valid = 1'b1; evt_loc = TBL[i].loc; evt_src = TBL[i].data[3:0]; end
        2'd1: begin wr_en = 1'b1; acc_loc = TBL[i].loc; acc_sel = TBL[i].sel;
                    wr_be = TBL[i].be; wr_data = TBL[i].data; end
        default: begin rd_en = 1'b1; acc_loc = TBL[i].loc; acc_sel = TBL[i].sel; end
      endcase
      @(negedge clk);
      idle();
      if (TBL[i].kind == 2'd2) begin
        chk($sformatf("R%0d step %0d data", TBL[i].req, i), rd_data, TBL[i].exp);
        chk($sformatf("R%0d step %0d irq", TBL[i].req, i), {31'b0, irq}, {31'b0, TBL[i].exp_irq});
      end
    end

    // R11: line rises on the edge that latches the event
    act_loc = 3'd2;
    @(negedge clk);
    evt_valid = 1'b1; evt_loc = 3'd2; evt_src = 4'h1;
    @(negedge clk);
    idle();
    chk("R11 irq same edge as event", {31'b0, irq}, 32'h1);

    // R10: event and clear of the same bit on one edge
    @(negedge clk);
    evt_valid = 1'b1; evt_loc = 3'd2; evt_src = 4'h1;
    wr_en = 1'b1; acc_loc = 3'd2; acc_sel = 2'd1; wr_be = 4'hF; wr_data = 32'h1;
    @(negedge clk);
    idle();
    rd(3'd2, 2'd1);
    chk("R10 event beats clear", rd_data, 32'h1);

    // R10: clear one bit while another is set
    @(negedge clk);
    evt_valid = 1'b1; evt_loc = 3'd2; evt_src = 4'h2;
    wr_en = 1'b1; acc_loc = 3'd2; acc_sel = 2'd1; wr_be = 4'hF; wr_data = 32'h1;
    @(negedge clk);
    idle();
    rd(3'd2, 2'd1);
    chk("R10 clear and set mixed", rd_data, 32'h2);
    chk("R6 line held", {31'b0, irq}, 32'h1);

    // R11: line falls on the edge of the clearing write
    @(negedge clk);
    wr_en = 1'b1; acc_loc = 3'd2; acc_sel = 2'd1; wr_be = 4'hF; wr_data = 32'h2;
    @(negedge clk);
    idle();
    chk("R11 irq same edge as clear", {31'b0, irq}, 32'h0);

    // R7: reset mid-run restores defaults
    @(negedge clk);
    evt_valid = 1'b1; evt_loc = 3'd2; evt_src = 4'hF;
    @(negedge clk);
    idle();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R7 irq after second reset", {31'b0, irq}, 32'h0);
    rd(3'd2, 2'd0);
    chk("R7 enable after second reset", rd_data, 32'h10);
    rd(3'd2, 2'd1);
    chk("R7 status after second reset", rd_data, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule